// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block keeps the instruction byte queue of a 16-bit segmented processor core topped up. It holds the current code segment and a fetch offset, forms the physical byte address as segment times sixteen plus offset, and reads 16-bit words over a simple request/acknowledge memory bus addressed in words. Each returned word is unpacked into bytes, low byte first. The bytes are pushed into an external byte queue one per clock, and pushing stops whenever the queue reports that it is full.

When the core changes its instruction stream, it pulses a load strobe with a new segment and offset. The unit then clears the byte queue through a flush output and points its address at the new location on the next cycle. A read that is still in flight at that moment is allowed to finish on the bus, but its data is thrown away. Fetching then resumes from the new location. If the new location starts at an odd byte, the low byte of the first word is dropped.

The memory slave is expected to capture the word address in the first cycle of each request. A request ends with a single-cycle acknowledge that carries the data. If the request is still high in the cycle after an acknowledge, that is a new transaction.

Top module: `insn_prefetch`

## Requirements
- R1: While reset is held, `mem_req`, `fifo_we` and `fifo_flush` are low, the segment is 0xFFFF and the offset is 0. The word address is 0x7FFF8, and the first bytes pushed after reset come from byte address 0xFFFF0.
- R2: `mem_waddr` equals ((segment << 4) + offset) mod 2^20, shifted right by one.
- R3: An accepted word is pushed low byte (bits 7:0) first and then high byte (bits 15:8), one byte per cycle. The first push happens in the cycle after the acknowledge.
- R4: When fetching begins at an odd byte address, only the high byte of that first word is pushed.
- R5: `fifo_flush` is high in exactly the cycle after a load strobe. In that cycle `mem_waddr` already shows the newly loaded segment and offset.
- R6: Data from a read that is outstanding when a load strobe arrives never reaches the queue. The request stays high until that stale acknowledge, and the next transaction fetches from the new location.
- R7: A request that is low while `fifo_full` is high stays low in the next cycle. A request already raised is kept until it is acknowledged.
- R8: No byte is pushed while `fifo_full` is high. A byte held at that time is kept and pushed after the flag drops, so the byte stream is contiguous.
- R9: `mem_req` stays high until `mem_ack`. A new word is requested only once the held bytes are drained or their last one is being pushed.
- R10: The offset advances by the number of bytes fetched. It wraps from 0xFFFF to 0x0000 within the same segment.
- R11: `fifo_we` is never high in a cycle where `fifo_flush` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_in | input | 16 | Code segment loaded by the strobe |
| ofs_in | input | 16 | Instruction offset loaded by the strobe |
| load | input | 1 | Redirect strobe |
| fifo_full | input | 1 | Byte queue cannot accept a byte |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Single-cycle read completion |
| mem_waddr | output | 19 | Word address of the current fetch |
| mem_req | output | 1 | Read request, held until acknowledged |
| fifo_we | output | 1 | Push one byte into the queue |
| fifo_wdata | output | 8 | Byte being pushed |
| fifo_flush | output | 1 | Clear the byte queue |

## Verification
The bound checker watches the local handshake rules on every cycle. These are: flush following a load, the address after a load, no push during flush or while full, no new request raised while full, and requests held until acknowledged. Byte ordering, odd-start dropping, stale-data discard, offset wrap and the continuity of the stream across a full stall all depend on whole sequences. Only the bench's cycle-accurate reference model and its scenario byte checks can show those.

// File: rtl/prefetch_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the instruction prefetch unit.
// Assumes a 16-bit memory word split into two 8-bit lanes.
package prefetch_pkg;
    localparam int BYTE_W  = 8;
    localparam int LANES   = 2;
    localparam int WORD_W  = BYTE_W * LANES;

    // Held word and which of its lanes still wait to be pushed.
    typedef struct packed {
        logic              lo_v;
        logic              hi_v;
        logic [WORD_W-1:0] word;
    } pf_hold_t;
endpackage

// File: rtl/pf_addr_gen.sv
`timescale 1ns/1ps
// Holds the code segment and turns segment plus fetch offset into a word
// address. Assumes the physical space is PHYS_W bits and wraps modulo 2^PHYS_W.
module pf_addr_gen #(
    parameter int          SEG_W     = 16,
    parameter int          OFS_W     = 16,
    parameter int          SEG_SHIFT = 4,
    parameter int          PHYS_W    = 20,
    parameter int unsigned SEG_RST   = 32'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SEG_W-1:0]  new_seg,
    input  logic [OFS_W-1:0]  fetch_ofs,
    output logic [PHYS_W-2:0] waddr
);
    localparam int WADDR_W = PHYS_W - 1;

    logic [SEG_W-1:0]  seg_q;
    logic [PHYS_W-1:0] seg_base;
    logic [PHYS_W-1:0] ofs_ext;
    logic [PHYS_W-1:0] phys;

    // Segment register: reset value, replaced on a redirect.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seg_q <= SEG_W'(SEG_RST);
        else if (load)
            seg_q <= new_seg;
    end

    // Physical byte address, then drop the byte-select bit.
    always_comb begin
        seg_base = PHYS_W'(seg_q) << SEG_SHIFT;
        ofs_ext  = PHYS_W'(fetch_ofs);
        phys     = seg_base + ofs_ext;
        waddr    = WADDR_W'(phys >> 1);
    end
endmodule

// File: rtl/pf_bus_ctl.sv
`timescale 1ns/1ps
// Memory-side control: owns the fetch offset, the request line and the
// stale-read marker. Assumes each mem_ack closes exactly one transaction and
// that the slave latches the address in a transaction's first cycle.
module pf_bus_ctl #(
    parameter int          OFS_W   = 16,
    parameter int unsigned OFS_RST = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OFS_W-1:0] new_ofs,
    input  logic             fifo_full,
    input  logic             mem_ack,
    input  logic             buf_free,
    output logic             mem_req,
    output logic [OFS_W-1:0] fetch_ofs,
    output logic             take,
    output logic             take_odd
);
    logic             req_q, req_n;
    logic             stale_q, stale_n;
    logic [OFS_W-1:0] ofs_q, ofs_n;
    logic [OFS_W-1:0] next_word_ofs;
    logic             start_ok;
    logic             pending;

    assign pending  = req_q && !mem_ack;
    // Accept returned data only for a live (non-stale) read outside a redirect.
    assign take     = req_q && mem_ack && !stale_q && !load;
    assign take_odd = ofs_q[0];
    assign start_ok = buf_free && !take && !fifo_full;
    assign next_word_ofs = {ofs_q[OFS_W-1:1] + (OFS_W-1)'(1), 1'b0};

    // Next-state selection for request, stale marker and offset.
    always_comb begin
        if (load) begin
            req_n   = pending;
            stale_n = pending;
            ofs_n   = new_ofs;
        end else begin
            req_n   = pending ? 1'b1 : start_ok;
            stale_n = stale_q && !mem_ack;
            ofs_n   = take ? next_word_ofs : ofs_q;
        end
    end

    // Control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            stale_q <= 1'b0;
            ofs_q   <= OFS_W'(OFS_RST);
        end else begin
            req_q   <= req_n;
            stale_q <= stale_n;
            ofs_q   <= ofs_n;
        end
    end

    assign mem_req   = req_q;
    assign fetch_ofs = ofs_q;
endmodule

// File: rtl/pf_byte_buf.sv
`timescale 1ns/1ps
// Holds one fetched word and pushes its valid lanes into the byte queue, low
// lane first, one per cycle while the queue has room. Assumes a new word is
// only offered when the hold register is empty.
module pf_byte_buf
    import prefetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              take,
    input  logic              take_odd,
    input  logic [WORD_W-1:0] rdata,
    input  logic              fifo_full,
    output logic              fifo_we,
    output logic [BYTE_W-1:0] fifo_wdata,
    output logic              buf_free
);
    pf_hold_t hold_q, hold_n;
    logic     any_v;
    logic     one_left;

    assign any_v      = hold_q.lo_v || hold_q.hi_v;
    assign one_left   = hold_q.lo_v ^ hold_q.hi_v;
    assign fifo_we    = any_v && !fifo_full;
    assign fifo_wdata = hold_q.lo_v ? hold_q.word[BYTE_W-1:0]
                                    : hold_q.word[WORD_W-1:BYTE_W];
    // Free after this cycle: empty now, or the final byte leaves now.
    assign buf_free   = !any_v || (fifo_we && one_left);

    // Next hold contents: clear, load a word, or retire the pushed lane.
    always_comb begin
        hold_n = hold_q;
        if (load) begin
            hold_n.lo_v = 1'b0;
            hold_n.hi_v = 1'b0;
        end else if (take) begin
            hold_n.lo_v = !take_odd;
            hold_n.hi_v = 1'b1;
            hold_n.word = rdata;
        end else if (fifo_we) begin
            if (hold_q.lo_v)
                hold_n.lo_v = 1'b0;
            else
                hold_n.hi_v = 1'b0;
        end
    end

    // Hold register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else
            hold_q <= hold_n;
    end
endmodule

// File: rtl/insn_prefetch.sv
`timescale 1ns/1ps
// Instruction prefetch unit top: ties the address generator, bus control and
// byte hold stage together and registers the queue flush. Assumes an external
// byte queue and a word-wide request/acknowledge memory slave.
module insn_prefetch #(
    parameter int          SEG_W     = 16,
    parameter int          OFS_W     = 16,
    parameter int          SEG_SHIFT = 4,
    parameter int          PHYS_W    = 20,
    parameter int unsigned SEG_RST   = 32'hFFFF,
    parameter int unsigned OFS_RST   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  seg_in,
    input  logic [OFS_W-1:0]  ofs_in,
    input  logic              load,
    input  logic              fifo_full,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ack,
    output logic [PHYS_W-2:0] mem_waddr,
    output logic              mem_req,
    output logic              fifo_we,
    output logic [7:0]        fifo_wdata,
    output logic              fifo_flush
);
    logic [OFS_W-1:0] fetch_ofs;
    logic             take;
    logic             take_odd;
    logic             buf_free;
    logic             flush_q;

    pf_addr_gen #(
        .SEG_W(SEG_W), .OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT),
        .PHYS_W(PHYS_W), .SEG_RST(SEG_RST)
    ) addr_i (
        .clk(clk), .rst_n(rst_n), .load(load), .new_seg(seg_in),
        .fetch_ofs(fetch_ofs), .waddr(mem_waddr)
    );

    pf_bus_ctl #(
        .OFS_W(OFS_W), .OFS_RST(OFS_RST)
    ) bus_i (
        .clk(clk), .rst_n(rst_n), .load(load), .new_ofs(ofs_in),
        .fifo_full(fifo_full), .mem_ack(mem_ack), .buf_free(buf_free),
        .mem_req(mem_req), .fetch_ofs(fetch_ofs), .take(take),
        .take_odd(take_odd)
    );

    pf_byte_buf buf_i (
        .clk(clk), .rst_n(rst_n), .load(load), .take(take),
        .take_odd(take_odd), .rdata(mem_rdata), .fifo_full(fifo_full),
        .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .buf_free(buf_free)
    );

    // Queue flush follows a redirect by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flush_q <= 1'b0;
        else
            flush_q <= load;
    end

    assign fifo_flush = flush_q;
endmodule

// File: rtl/pf_chk.sv
`timescale 1ns/1ps
// Protocol checker for insn_prefetch, attached through bind below.
module pf_chk #(
    parameter int SEG_W     = 16,
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PHYS_W    = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEG_W-1:0]  seg_in,
    input logic [OFS_W-1:0]  ofs_in,
    input logic              load,
    input logic              fifo_full,
    input logic              mem_ack,
    input logic [PHYS_W-2:0] mem_waddr,
    input logic              mem_req,
    input logic              fifo_we,
    input logic              fifo_flush
);
    logic [PHYS_W-1:0] exp_phys_q;

    // Expected location captured at each redirect.
    always_ff @(posedge clk) begin
        if (load)
            exp_phys_q <= (PHYS_W'(seg_in) << SEG_SHIFT) + PHYS_W'(ofs_in);
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !fifo_we && !fifo_flush));

    assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (mem_waddr == exp_phys_q[PHYS_W-1:1]));

    assert_flush_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> fifo_flush);

    assert_flush_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> $past(load));

    assert_idle_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !mem_req) |=> !mem_req);

    assert_no_start_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && fifo_full) |=> !mem_req);

    assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_we);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

    assert_no_push_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_we && fifo_flush));
endmodule

bind insn_prefetch pf_chk #(
    .SEG_W(SEG_W), .OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .PHYS_W(PHYS_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .seg_in(seg_in), .ofs_in(ofs_in), .load(load),
    .fifo_full(fifo_full), .mem_ack(mem_ack), .mem_waddr(mem_waddr),
    .mem_req(mem_req), .fifo_we(fifo_we), .fifo_flush(fifo_flush)
);

// File: tb/insn_prefetch_tb_top.sv
`timescale 1ns/1ps
module insn_prefetch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] seg_in = '0;
    logic [15:0] ofs_in = '0;
    logic        load = 1'b0;
    logic        fifo_full = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [18:0] mem_waddr;
    logic        mem_req;
    logic        fifo_we;
    logic [7:0]  fifo_wdata;
    logic        fifo_flush;

    int total = 0;
    int bad = 0;
    int lat = 0;
    bit cmp_en = 0;
    logic [7:0] got[$];

    // Reference model state.
    int unsigned m_cs = 32'hFFFF;
    int unsigned m_ofs = 0;
    bit m_req = 0, m_stale = 0, m_flush = 0;
    logic [7:0] m_q[$];

    // Memory slave state.
    bit s_busy = 0;
    int s_cnt = 0;
    logic [18:0] s_addr = '0;

    always #2.5 clk = ~clk;

    insn_prefetch dut_i (
        .clk(clk), .rst_n(rst_n), .seg_in(seg_in), .ofs_in(ofs_in),
        .load(load), .fifo_full(fifo_full), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_waddr(mem_waddr), .mem_req(mem_req),
        .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .fifo_flush(fifo_flush)
    );

    function automatic logic [15:0] mword(logic [18:0] a);
        return {~a[7:0] ^ {5'b0, a[18:16]}, a[7:0] + a[15:8]};
    endfunction

    function automatic logic [7:0] exp_byte(int unsigned seg, int unsigned ofs, int k);
        int unsigned p;
        logic [15:0] w;
        p = ((seg << 4) + ((ofs + k) & 32'hFFFF)) & 32'hFFFFF;
        w = mword(19'(p >> 1));
        return p[0] ? w[15:8] : w[7:0];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: advances on every rising edge from the sampled inputs.
    always @(posedge clk) begin
        bit we_e, free_e, take_e, start_e, pend_e;
        logic [15:0] w;
        if (!rst_n) begin
            m_cs = 32'hFFFF; m_ofs = 0; m_req = 0; m_stale = 0; m_flush = 0;
            m_q.delete();
        end else begin
            we_e   = !fifo_full && (m_q.size() > 0);
            free_e = (m_q.size() == 0) || (m_q.size() == 1 && we_e);
            pend_e = m_req && !mem_ack;
            if (load) begin
                m_cs = seg_in; m_ofs = ofs_in;
                m_stale = pend_e; m_req = pend_e; m_flush = 1;
                m_q.delete();
            end else begin
                m_flush = 0;
                take_e  = mem_ack && m_req && !m_stale;
                start_e = free_e && !take_e && !fifo_full;
                if (mem_ack && m_req && m_stale) m_stale = 0;
                if (we_e) void'(m_q.pop_front());
                if (take_e) begin
                    w = mem_rdata;
                    if (m_ofs[0] == 1'b0) m_q.push_back(w[7:0]);
                    m_q.push_back(w[15:8]);
                    m_ofs = ((m_ofs | 1) + 1) & 32'hFFFF;
                end
                m_req = pend_e ? 1'b1 : start_e;
            end
        end
    end

    // Compare against the model and record pushed bytes, away from the edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R9 mem_req", 32'(mem_req), 32'(m_req));
            chk("R2 mem_waddr", 32'(mem_waddr), ((((m_cs << 4) + m_ofs) & 32'hFFFFF) >> 1));
            chk("R3 fifo_we", 32'(fifo_we), 32'(!fifo_full && m_q.size() > 0));
            if (fifo_we && m_q.size() > 0) chk("R3 fifo_wdata", 32'(fifo_wdata), 32'(m_q[0]));
            chk("R5 fifo_flush", 32'(fifo_flush), 32'(m_flush));
            if (fifo_flush) got.delete();
            if (fifo_we) got.push_back(fifo_wdata);
        end
    end

    // Memory slave: latches the address in the first request cycle, answers after lat cycles.
    always @(negedge clk) begin
        #1;
        if (!rst_n) begin
            mem_ack = 0; s_busy = 0;
        end else begin
            if (mem_ack) begin
                mem_ack = 0; s_busy = 0;
            end
            if (mem_req && !s_busy) begin
                s_busy = 1; s_addr = mem_waddr; s_cnt = lat;
            end else if (s_busy) begin
                s_cnt--;
            end
            if (s_busy && s_cnt == 0) begin
                mem_ack = 1; mem_rdata = mword(s_addr);
            end
        end
    end

    task automatic do_load(logic [15:0] s, logic [15:0] o);
        @(negedge clk); #1;
        load = 1; seg_in = s; ofs_in = o;
        @(negedge clk); #1;
        load = 0;
        // Now inside the flush cycle.
        chk("R5 flush after load", 32'(fifo_flush), 1);
        chk("R11 no push while flushing", 32'(fifo_we), 0);
        chk("R2 address after load", 32'(mem_waddr), ((((32'(s) << 4) + 32'(o)) & 32'hFFFFF) >> 1));
    endtask

    task automatic wait_bytes(int n);
        while (got.size() < n) @(negedge clk);
    endtask

    task automatic chk_seq(string tag, int unsigned s, int unsigned o, int n);
        for (int k = 0; k < n; k++)
            chk(tag, 32'(got[k]), 32'(exp_byte(s, o, k)));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL R9 watchdog actual=timeout expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: quiet outputs and boot address during reset.
        chk("R1 req in reset", 32'(mem_req), 0);
        chk("R1 we in reset", 32'(fifo_we), 0);
        chk("R1 flush in reset", 32'(fifo_flush), 0);
        chk("R1 boot address", 32'(mem_waddr), 32'h7FFF8);
        cmp_en = 1;
        #1 rst_n = 1;

        // R1/R3: boot stream, zero latency, low byte first.
        wait_bytes(6);
        chk_seq("R3 boot byte order", 32'hFFFF, 0, 6);
        chk("R1 first byte", 32'(got[0]), 32'(mword(19'h7FFF8) & 16'hFF));

        // R4: odd start drops the low byte of the first word.
        lat = 2;
        do_load(16'h1234, 16'h0101);
        wait_bytes(5);
        chk_seq("R4 odd start", 32'h1234, 32'h0101, 5);

        // R6: redirect while a slow read is in flight.
        lat = 5;
        do_load(16'h2000, 16'h0000);
        repeat (3) @(negedge clk);
        chk("R6 read outstanding before redirect", 32'(mem_req), 1);
        do_load(16'hDEAD, 16'h0008);
        chk("R6 request kept for stale ack", 32'(mem_req), 1);
        wait_bytes(6);
        chk_seq("R6 no stale data", 32'hDEAD, 32'h0008, 6);

        // R7/R8: stall on full, then resume without skipping.
        lat = 1;
        do_load(16'h0040, 16'h0010);
        wait_bytes(3);
        #1 fifo_full = 1;
        repeat (3) @(negedge clk);
        n = got.size();
        repeat (20) @(negedge clk);
        chk("R8 no push while full", 32'(got.size()), 32'(n));
        chk("R7 no request while full", 32'(mem_req), 0);
        #1 fifo_full = 0;
        wait_bytes(10);
        chk_seq("R8 contiguous after stall", 32'h0040, 32'h0010, 10);

        // R10: offset wraps inside the segment.
        lat = 0;
        do_load(16'h0100, 16'hFFFE);
        wait_bytes(4);
        chk_seq("R10 offset wrap", 32'h0100, 32'hFFFE, 4);

        // R11: redirect in the middle of a stream with bytes held.
        do_load(16'h0300, 16'h0021);
        wait_bytes(3);
        chk_seq("R11 stream after mid-word redirect", 32'h0300, 32'h0021, 3);

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule